// File: doc/BRIEF.md
# Clocked Serial Receive Buffer

This block is the receive half of a synchronous serial port. Serial data is captured on the rising edges of an externally supplied shift clock and assembled most significant bit first in a shift register. When the frame is complete, the word is copied into a 16-bit receive buffer in one step. The frame is either 8 or 16 bits long, chosen by a length select. Software reads the buffer through a simple read port at one of two addresses. One address gives the full 16-bit buffer. The other gives only its low byte, zero-extended.

In receive-only operation, each read of the buffer that is accepted while the port is idle launches the next frame. Software therefore collects one word and requests the following one with a single access. A busy flag covers the time from that read to the capture of the final bit. A one-cycle completion pulse marks the moment the buffer is loaded. Dropping the enable clears the buffer and abandons any frame in progress. An asynchronous reset does the same.

Top module: `csi_rx_buf`

## Requirements
- R1: After reset, busy_o and done_o are 0, and reads at both buffer addresses return 0x0000.
- R2: When en_i=1 and tx_mode_i=0, a read strobe (rd_i=1) at address 0x4 or 0x6 while busy_o=0 sets busy_o from the next clock cycle.
- R3: During a 16-bit frame (len16_i=1 at the start), sixteen shift clock rising edges are captured with sd_i read most significant bit first. The resulting word is then returned at address 0x4.
- R4: During an 8-bit frame (len16_i=0 at the start), eight rising edges are captured. The buffer then holds the received byte in bits 7..0 and zeros in bits 15..8.
- R5: The buffer load, the clearing of busy_o and a done_o pulse exactly one clock wide all happen on the same clock edge, once per frame.
- R6: A read at address 0x4 returns the whole buffer. A read at 0x6 returns {8'h00, buffer[7:0]}. A read at any other address returns 0 and starts nothing.
- R7: A read while busy_o=1 neither restarts nor aborts the frame. The frame still completes after its remaining bits.
- R8: While en_i=0, the buffer is cleared, busy_o is 0, any frame in progress is dropped, and reads start nothing.
- R9: When tx_mode_i=1, a read does not start a reception.
- R10: Shift clock edges while busy_o=0 change neither the buffer nor done_o.
- R11: len16_i is sampled when a frame starts. Changing it during the frame does not alter that frame's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Interface enable; 0 clears and holds idle |
| tx_mode_i | input | 1 | 0 = receive-only (reads start frames), 1 = transmit/receive |
| len16_i | input | 1 | Frame length: 0 = 8 bits, 1 = 16 bits |
| sck_i | input | 1 | Shift clock, asynchronous, sampled on its rising edge |
| sd_i | input | 1 | Serial data in |
| addr_i | input | 4 | Read address |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Read data |
| busy_o | output | 1 | Reception in progress |
| done_o | output | 1 | One-cycle pulse when the buffer loads |

## Verification
The two functions that can coincide are a software read of the buffer and the buffer load at the end of a frame. To provoke this, the bench holds the read strobe high on every cycle while the last shift clock edge of a frame passes through the synchronizer. It then judges three things at the cycle where done_o appears. The cycle before must return the old word. The done_o cycle must return the new word with busy_o low. The read present during the completion edge must not have started a frame, and the still-present read on the following edge must start one.

// File: rtl/csi_rx_pkg.sv
package csi_rx_pkg;
  typedef enum logic [1:0] {
    VIEW_NONE = 2'd0,
    VIEW_HALF = 2'd1,
    VIEW_BYTE = 2'd2
  } view_e;
endpackage

// File: rtl/csi_rx_sync.sv
// Synchronizes shift clock and data together; flags shift clock rising edges.
module csi_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sd_i,
  output logic rise_o,
  output logic sd_o
);
  logic [STAGES-1:0] sck_q, sd_q;
  logic              sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= '0;
      sd_q    <= '0;
      sck_d_q <= 1'b0;
    end else begin
      sck_q   <= {sck_q[STAGES-2:0], sck_i};
      sd_q    <= {sd_q[STAGES-2:0], sd_i};
      sck_d_q <= sck_q[STAGES-1];
    end
  end

  assign rise_o = sck_q[STAGES-1] & ~sck_d_q;
  assign sd_o   = sd_q[STAGES-1];
endmodule

// File: rtl/csi_rx_shift.sv
module csi_rx_shift #(
  parameter int W  = 16,
  parameter int NB = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         start_i,
  input  logic         len16_i,
  input  logic         rise_i,
  input  logic         sd_i,
  output logic         busy_o,
  output logic         load_o,
  output logic [W-1:0] word_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          long_q;
  logic [CW-1:0] last;

  assign last   = long_q ? CW'(W - 1) : CW'(NB - 1);
  assign word_o = {sh_q[W-2:0], sd_i};
  assign load_o = busy_o & rise_i & (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      long_q <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (!en_i) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      long_q <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= load_o;
      if (start_i) begin
        sh_q   <= '0;
        cnt_q  <= '0;
        long_q <= len16_i;
        busy_o <= 1'b1;
      end else if (busy_o && rise_i) begin
        sh_q  <= word_o;
        cnt_q <= cnt_q + CW'(1);
        if (load_o) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csi_rx_regs.sv
module csi_rx_regs
  import csi_rx_pkg::*;
#(
  parameter int             W         = 16,
  parameter int             AW        = 4,
  parameter logic [AW-1:0]  HALF_ADDR = 'h4,
  parameter logic [AW-1:0]  BYTE_ADDR = 'h6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tx_mode_i,
  input  logic          busy_i,
  input  logic          load_i,
  input  logic [W-1:0]  word_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  output logic          start_o,
  output logic [W-1:0]  buf_o,
  output logic [W-1:0]  rdata_o
);
  view_e view;

  always_comb begin
    view = VIEW_NONE;
    if (rd_i && addr_i == HALF_ADDR) view = VIEW_HALF;
    else if (rd_i && addr_i == BYTE_ADDR) view = VIEW_BYTE;
  end

  assign start_o = (view != VIEW_NONE) & en_i & ~tx_mode_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      buf_o <= '0;
    else if (!en_i)   buf_o <= '0;
    else if (load_i)  buf_o <= word_i;
  end

  always_comb begin
    unique case (view)
      VIEW_HALF: rdata_o = buf_o;
      VIEW_BYTE: rdata_o = {{(W-8){1'b0}}, buf_o[7:0]};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/csi_rx_buf.sv
module csi_rx_buf #(
  parameter int            W         = 16,
  parameter int            NB        = 8,
  parameter int            AW        = 4,
  parameter int            STAGES    = 2,
  parameter logic [AW-1:0] HALF_ADDR = 'h4,
  parameter logic [AW-1:0] BYTE_ADDR = 'h6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tx_mode_i,
  input  logic          len16_i,
  input  logic          sck_i,
  input  logic          sd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  output logic [W-1:0]  rdata_o,
  output logic          busy_o,
  output logic          done_o
);
  logic         rise_w, sd_w, start_w, load_w;
  logic [W-1:0] word_w, buf_q;

  csi_rx_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .sd_i, .rise_o(rise_w), .sd_o(sd_w)
  );

  csi_rx_shift #(.W(W), .NB(NB)) u_shift (
    .clk_i, .rst_ni, .en_i,
    .start_i(start_w), .len16_i, .rise_i(rise_w), .sd_i(sd_w),
    .busy_o, .load_o(load_w), .word_o(word_w), .done_o
  );

  csi_rx_regs #(.W(W), .AW(AW), .HALF_ADDR(HALF_ADDR), .BYTE_ADDR(BYTE_ADDR)) u_regs (
    .clk_i, .rst_ni, .en_i, .tx_mode_i,
    .busy_i(busy_o), .load_i(load_w), .word_i(word_w),
    .addr_i, .rd_i, .start_o(start_w), .buf_o(buf_q), .rdata_o
  );
endmodule

// File: rtl/csi_rx_buf_chk.sv
module csi_rx_buf_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         start_w,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] buf_q
);
  p_start_sets_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w && en_i) |=> busy_o);

  p_busy_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_w));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_done_after_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  p_disable_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (buf_q == '0 && !busy_o && !done_o));

  p_buf_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(buf_q) |-> (done_o || !$past(en_i)));
endmodule

bind csi_rx_buf csi_rx_buf_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .en_i, .start_w(start_w), .busy_o, .done_o, .buf_q(buf_q)
);

// File: tb/csi_rx_buf_tb.sv
module csi_rx_buf_tb;
  localparam logic [3:0] HA = 4'h4;
  localparam logic [3:0] BA = 4'h6;

  logic        clk = 0, rst_ni = 0, en = 0, tx_mode = 0, len16 = 0;
  logic        sck = 0, sd = 0, rd = 0;
  logic [3:0]  addr = 0;
  logic [15:0] rdata;
  logic        busy, done;
  int          vecs = 0, errs = 0, done_cnt = 0;

  always #2 clk = ~clk;

  csi_rx_buf u_dut (
    .clk_i(clk), .rst_ni, .en_i(en), .tx_mode_i(tx_mode), .len16_i(len16),
    .sck_i(sck), .sd_i(sd), .addr_i(addr), .rd_i(rd),
    .rdata_o(rdata), .busy_o(busy), .done_o(done)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_view(input logic [3:0] a, output logic [15:0] v);
    addr = a; rd = 1; #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic send_bit(input logic b);
    sd = b; sck = 0; repeat (4) @(negedge clk);
    sck = 1; repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] d, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(d[i]);
    sck = 0; repeat (2) @(negedge clk);
  endtask

  task automatic pulse_disable();
    en = 0; @(negedge clk); en = 1; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [15:0] v, prev, exp_prev;
    int dc;
    repeat (3) @(negedge clk);
    rst_ni = 1; en = 1; @(negedge clk);

    // R1 reset state
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 done", {15'd0, done}, 16'd0);
    tx_mode = 1;
    rd_view(HA, v); check("R1 half", v, 16'h0);
    rd_view(BA, v); check("R1 byte", v, 16'h0);
    // R9 tx mode read does not start
    check("R9 no start", {15'd0, busy}, 16'd0);
    tx_mode = 0;

    // R6 other address: no data, no start
    rd_view(4'h5, v); check("R6 other addr", v, 16'h0);
    check("R6 other no start", {15'd0, busy}, 16'd0);

    // R10 idle shift clocks ignored
    dc = done_cnt;
    send_bits(16'hA5C3, 16);
    check("R10 done", 16'(done_cnt - dc), 16'd0);

    // R2 R4 R6: exhaustive 8-bit sweep; each read checks previous word and starts next
    len16 = 0; exp_prev = 16'h0;
    for (int i = 0; i < 256; i++) begin
      rd_view((i % 2) ? BA : HA, v);
      check("R6 R4 view", v, exp_prev);
      check("R2 busy", {15'd0, busy}, 16'd1);
      dc = done_cnt;
      send_bits(16'(i), 8);
      check("R5 one done", 16'(done_cnt - dc), 16'd1);
      check("R5 busy clr", {15'd0, busy}, 16'd0);
      exp_prev = 16'(i);
    end
    tx_mode = 1;
    rd_view(HA, v); check("R4 upper zero", v, 16'h00FF);
    tx_mode = 0;

    // R3 16-bit patterns
    len16 = 1;
    for (int i = 0; i < 48; i++) begin
      logic [15:0] d;
      d = (i < 16) ? (16'h1 << i) : 16'(i * 16'h9E37 + 16'h1234);
      rd_view(HA, v);
      dc = done_cnt;
      send_bits(d, 16);
      tx_mode = 1;
      rd_view(HA, v); check("R3 half", v, d);
      rd_view(BA, v); check("R6 byte", v, {8'h00, d[7:0]});
      tx_mode = 0;
      check("R5 one done 16", 16'(done_cnt - dc), 16'd1);
    end

    // R7 read while busy
    rd_view(HA, v);
    send_bits(16'h0000, 0);
    for (int i = 15; i >= 11; i--) send_bit(1'(16'hBEEF >> i));
    dc = done_cnt;
    rd_view(BA, v);
    check("R7 still busy", {15'd0, busy}, 16'd1);
    for (int i = 10; i >= 0; i--) send_bit(1'(16'hBEEF >> i));
    sck = 0; repeat (2) @(negedge clk);
    check("R7 one done", 16'(done_cnt - dc), 16'd1);
    tx_mode = 1; rd_view(HA, v); tx_mode = 0;
    check("R7 data", v, 16'hBEEF);

    // R11 length latched at start
    len16 = 0;
    rd_view(HA, v);
    for (int i = 7; i >= 5; i--) send_bit(1'(8'h6B >> i));
    len16 = 1;
    for (int i = 4; i >= 0; i--) send_bit(1'(8'h6B >> i));
    sck = 0; repeat (2) @(negedge clk);
    check("R11 done", {15'd0, busy}, 16'd0);
    tx_mode = 1; rd_view(HA, v); tx_mode = 0;
    check("R11 data", v, 16'h006B);

    // R8 disable mid-frame
    rd_view(HA, v);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    en = 0; @(negedge clk);
    check("R8 busy", {15'd0, busy}, 16'd0);
    rd_view(HA, v); check("R8 cleared", v, 16'h0);
    check("R8 no start", {15'd0, busy}, 16'd0);
    en = 1; @(negedge clk);
    dc = done_cnt;
    for (int i = 0; i < 11; i++) send_bit(1'b1);
    check("R8 no done", 16'(done_cnt - dc), 16'd0);

    // R5 read coinciding with buffer load
    rd_view(HA, v);
    for (int i = 15; i >= 1; i--) send_bit(1'(16'h3C5A >> i));
    sd = 0; sck = 0; repeat (4) @(negedge clk);
    addr = HA; rd = 1; #1 prev = rdata;
    sck = 1;
    begin
      int seen = 0;
      for (int k = 0; k < 10 && seen == 0; k++) begin
        @(negedge clk); #1;
        if (done) begin
          seen = 1;
          check("R5 old before load", prev, 16'h0);
          check("R5 new at load", rdata, 16'h3C5A);
          check("R5 busy low at load", {15'd0, busy}, 16'd0);
          @(negedge clk); #1;
          check("R2 restart after load", {15'd0, busy}, 16'd1);
        end else prev = rdata;
      end
      check("R5 load seen", 16'(seen), 16'd1);
    end
    rd = 0; sck = 0;
    pulse_disable();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule